// File: doc/BRIEF.md
# Single-Slope PWM Timer with Shadowed Compare Registers

This block is an up-counting timer with two compare channels that produce single-slope (sawtooth) pulse-width modulated waveforms. The counter steps once per enabled cycle, where the enable comes from an external prescaler. It runs from zero up to a period limit and then restarts at zero. The period limit is chosen by a mode input from five sources: three fixed resolutions, the active value of compare channel A, or a directly written period register.

The compare values are shadowed. A write lands in a staging register, and the value the counter is compared against changes only on the enabled cycle in which the counter hits its limit. The period register has no shadow. If it is written with a value below the running count, the period limit is missed, and the counter runs on to the top of its range and wraps to zero before it can match. Three sticky flags report period end, compare-A match and period-register match. Each flag is cleared by a one-cycle clear strobe.

Top module: `fast_pwm_timer`

## Requirements
- R1: After reset the count, all flags, all compare values and the period register are zero. The count changes only on cycles where `tick_i` is high, and then by exactly +1, unless R2 applies.
- R2: `top_sel_i` picks the period limit: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the active compare-A value, and 4 to 7 give the period register. On a tick with the count equal to the limit, the count becomes 0 and `ovf_flag_o` is set.
- R3: If the count is above the limit, no period match occurs. The count steps up to 0xFFFF, wraps to 0x0000, and only then can meet the limit. No overflow flag or period-register flag is raised at the wrap.
- R4: A write to compare A or B updates only that channel's staging value. The active compare value takes the staged value on a tick with the count at the limit, and at no other time.
- R5: A write to the period register takes effect on the next cycle, inside the current period.
- R6: While `top_sel_i` is 0, 1 or 2, a compare write keeps only the low 8, 9 or 10 bits respectively, and the upper bits are stored as zero.
- R7: `cmpa_flag_o` is set on a tick where the count equals the active compare-A value. With `top_sel_i` = 3, this happens on the same cycle that sets `ovf_flag_o`.
- R8: With `top_sel_i` at 4 to 7, `topreg_flag_o` is set on the same tick that sets `ovf_flag_o`.
- R9: Each channel has an internal level. It goes high on a tick where the count is at the limit or at 0xFFFF. It goes low on a tick where the count equals that channel's active compare value. If both happen on the same tick, high wins. With output mode 2, the waveform output shows this level, so it is high for counts 0 through the compare value.
- R10: Output mode 3 drives the complement of the level. Modes 0 and 1 hold the waveform output low.
- R11: A compare value above the period limit never matches. In mode 2 that waveform stays high and the channel's match never sets `cmpa_flag_o`.
- R12: A flag stays set until its clear strobe is high for a cycle. If a set event and a clear strobe occur on the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from prescaler |
| top_sel_i | input | 3 | Period-limit source select |
| cmp_a_wr_i | input | 1 | Write strobe, compare A staging register |
| cmp_b_wr_i | input | 1 | Write strobe, compare B staging register |
| top_wr_i | input | 1 | Write strobe, period register |
| wdata_i | input | 16 | Write data shared by all write strobes |
| mode_a_i | input | 2 | Output mode, channel A |
| mode_b_i | input | 2 | Output mode, channel B |
| clr_ovf_i | input | 1 | Clear strobe, overflow flag |
| clr_cmpa_i | input | 1 | Clear strobe, compare-A flag |
| clr_topreg_i | input | 1 | Clear strobe, period-register flag |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Period-end flag |
| cmpa_flag_o | output | 1 | Compare-A match flag |
| topreg_flag_o | output | 1 | Period-register match flag |
| wave_a_o | output | 1 | Waveform, channel A |
| wave_b_o | output | 1 | Waveform, channel B |

## Verification
The assertions check the following on every cycle:
- the count holds without a tick and steps by one otherwise;
- the count returns to zero, and the overflow flag is raised, exactly at the limit;
- the active compare-A value never moves except at the limit;
- the compare-A and period-register flags accompany the overflow flag in their modes;
- a set flag persists without a clear strobe.

Only the bench scenarios can show the following:
- the masking of compare writes in the fixed resolutions;
- the exact duty cycle and the inversion of the waveforms;
- the missed-limit run through 0xFFFF after a low period-register write;
- the immediate effect of the period register against the delayed effect of compare writes;
- a compare value above the limit never matching;
- set taking priority over clear.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  typedef enum logic [2:0] {
    TOP_FIX8  = 3'd0,
    TOP_FIX9  = 3'd1,
    TOP_FIX10 = 3'd2,
    TOP_CMPA  = 3'd3,
    TOP_REG   = 3'd4
  } top_sel_e;

  typedef enum logic [1:0] {
    OM_OFF0   = 2'd0,
    OM_OFF1   = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } out_mode_e;

  function automatic logic sel_is_fixed(input logic [2:0] sel);
    return sel < 3'(TOP_CMPA);
  endfunction

  function automatic logic sel_is_reg(input logic [2:0] sel);
    return sel >= 3'(TOP_REG);
  endfunction
endpackage

// File: rtl/fpwm_counter.sv
module fpwm_counter
  import fpwm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int FIX_BASE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [2:0]       top_sel_i,
  input  logic             top_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cmp_a_act_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] top_val_o,
  output logic [CNT_W-1:0] fix_mask_o,
  output logic             top_evt_o,
  output logic             wrap_evt_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] top_reg_q;
  logic [CNT_W-1:0] fix_top;
  logic             at_top;

  assign fix_top = ~(ALL_ONES << (FIX_BASE + int'(top_sel_i[1:0])));

  always_comb begin
    if (sel_is_fixed(top_sel_i))        top_val_o = fix_top;
    else if (top_sel_i == 3'(TOP_CMPA)) top_val_o = cmp_a_act_i;
    else                                top_val_o = top_reg_q;
  end

  assign fix_mask_o = sel_is_fixed(top_sel_i) ? fix_top : ALL_ONES;
  assign at_top     = (count_o == top_val_o);
  assign top_evt_o  = tick_i & at_top;
  // level set point: limit reached, or natural wrap after a missed limit
  assign wrap_evt_o = tick_i & (at_top | (count_o == ALL_ONES));

  // period register is unshadowed: applies on the next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       top_reg_q <= '0;
    else if (top_wr_i) top_reg_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_o <= '0;
    else if (top_evt_o) count_o <= '0;
    else if (tick_i)    count_o <= count_o + CNT_W'(1);
  end
endmodule

// File: rtl/fpwm_chan.sv
module fpwm_chan
  import fpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic             load_i,
  input  logic             wrap_evt_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       mode_i,
  output logic [CNT_W-1:0] act_o,
  output logic             match_o,
  output logic             wave_o
);
  logic [CNT_W-1:0] stage_q;
  logic             level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stage_q <= '0;
    else if (wr_i) stage_q <= wdata_i & mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_o <= '0;
    else if (load_i) act_o <= stage_q;
  end

  assign match_o = (count_i == act_o);

  // set at period start wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                level_q <= 1'b0;
    else if (wrap_evt_i)        level_q <= 1'b1;
    else if (tick_i && match_o) level_q <= 1'b0;
  end

  always_comb begin
    unique case (out_mode_e'(mode_i))
      OM_NONINV: wave_o = level_q;
      OM_INV:    wave_o = ~level_q;
      default:   wave_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpwm_flag.sv
module fpwm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/fast_pwm_timer.sv
module fast_pwm_timer
  import fpwm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int FIX_BASE = 8,
  parameter int N_CH     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [2:0]       top_sel_i,
  input  logic             cmp_a_wr_i,
  input  logic             cmp_b_wr_i,
  input  logic             top_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [1:0]       mode_a_i,
  input  logic [1:0]       mode_b_i,
  input  logic             clr_ovf_i,
  input  logic             clr_cmpa_i,
  input  logic             clr_topreg_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             cmpa_flag_o,
  output logic             topreg_flag_o,
  output logic             wave_a_o,
  output logic             wave_b_o
);
  localparam int N_FLAG = 3;

  logic [CNT_W-1:0]            top_val;
  logic [CNT_W-1:0]            fix_mask;
  logic                        top_evt;
  logic                        wrap_evt;
  logic [N_CH-1:0][CNT_W-1:0]  cmp_act;
  logic [N_CH-1:0]             cmp_match;
  logic [N_CH-1:0]             cmp_wr;
  logic [N_CH-1:0][1:0]        cmp_mode;
  logic [N_CH-1:0]             cmp_wave;
  logic [CNT_W-1:0]            cmp_a_act;
  logic [N_FLAG-1:0]           flag_set;
  logic [N_FLAG-1:0]           flag_clr;
  logic [N_FLAG-1:0]           flag_q;

  assign cmp_wr    = {cmp_b_wr_i, cmp_a_wr_i};
  assign cmp_mode  = {mode_b_i, mode_a_i};
  assign cmp_a_act = cmp_act[0];

  fpwm_counter #(
    .CNT_W   (CNT_W),
    .FIX_BASE(FIX_BASE)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .top_sel_i  (top_sel_i),
    .top_wr_i   (top_wr_i),
    .wdata_i    (wdata_i),
    .cmp_a_act_i(cmp_a_act),
    .count_o    (count_o),
    .top_val_o  (top_val),
    .fix_mask_o (fix_mask),
    .top_evt_o  (top_evt),
    .wrap_evt_o (wrap_evt)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    fpwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .wr_i      (cmp_wr[c]),
      .wdata_i   (wdata_i),
      .mask_i    (fix_mask),
      .load_i    (top_evt),
      .wrap_evt_i(wrap_evt),
      .count_i   (count_o),
      .mode_i    (cmp_mode[c]),
      .act_o     (cmp_act[c]),
      .match_o   (cmp_match[c]),
      .wave_o    (cmp_wave[c])
    );
  end

  assign wave_a_o = cmp_wave[0];
  assign wave_b_o = cmp_wave[1];

  // flag order: 0 overflow, 1 compare A, 2 period register
  assign flag_set[0] = top_evt;
  assign flag_set[1] = tick_i & cmp_match[0];
  assign flag_set[2] = top_evt & sel_is_reg(top_sel_i);
  assign flag_clr    = {clr_topreg_i, clr_cmpa_i, clr_ovf_i};

  for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
    fpwm_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (flag_set[f]),
      .clr_i (flag_clr[f]),
      .flag_o(flag_q[f])
    );
  end

  assign ovf_flag_o    = flag_q[0];
  assign cmpa_flag_o   = flag_q[1];
  assign topreg_flag_o = flag_q[2];
endmodule

// File: rtl/fpwm_checker.sv
module fpwm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [2:0]       top_sel_i,
  input logic             clr_ovf_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] top_val,
  input logic [CNT_W-1:0] cmp_a_act,
  input logic             ovf_flag_o,
  input logic             cmpa_flag_o,
  input logic             topreg_flag_o
);
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o != top_val) |=> count_o == $past(count_o) + CNT_W'(1)); // R1
  AST_TOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o == top_val) |=> count_o == '0); // R2
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o == top_val) |=> ovf_flag_o); // R2
  AST_STAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && count_o == top_val) |=> $stable(cmp_a_act)); // R4
  AST_CMPA_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && top_sel_i == 3'd3 && count_o == top_val) |=> cmpa_flag_o); // R7
  AST_TOPREG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && top_sel_i >= 3'd4 && count_o == top_val) |=> topreg_flag_o); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !clr_ovf_i) |=> ovf_flag_o); // R12
endmodule

bind fast_pwm_timer fpwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .top_sel_i    (top_sel_i),
  .clr_ovf_i    (clr_ovf_i),
  .count_o      (count_o),
  .top_val      (top_val),
  .cmp_a_act    (cmp_a_act),
  .ovf_flag_o   (ovf_flag_o),
  .cmpa_flag_o  (cmpa_flag_o),
  .topreg_flag_o(topreg_flag_o)
);

// File: tb/sim_fast_pwm_timer.sv
module sim_fast_pwm_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [2:0]  top_sel_i = 3'd0;
  logic        cmp_a_wr_i = 1'b0;
  logic        cmp_b_wr_i = 1'b0;
  logic        top_wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [1:0]  mode_a_i = 2'd0;
  logic [1:0]  mode_b_i = 2'd0;
  logic        clr_ovf_i = 1'b0;
  logic        clr_cmpa_i = 1'b0;
  logic        clr_topreg_i = 1'b0;
  logic [15:0] count_o;
  logic        ovf_flag_o, cmpa_flag_o, topreg_flag_o, wave_a_o, wave_b_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  fast_pwm_timer u0 (
    .clk_i, .rst_ni, .tick_i, .top_sel_i, .cmp_a_wr_i, .cmp_b_wr_i, .top_wr_i,
    .wdata_i, .mode_a_i, .mode_b_i, .clr_ovf_i, .clr_cmpa_i, .clr_topreg_i,
    .count_o, .ovf_flag_o, .cmpa_flag_o, .topreg_flag_o, .wave_a_o, .wave_b_o
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wait_count(input logic [15:0] v);
    int n = 0;
    while (count_o !== v) begin
      step();
      n++;
      if (n > 70000) begin
        check("R1", "count never reached target", 32'(count_o), 32'(v));
        break;
      end
    end
  endtask

  task automatic wr_a(input logic [15:0] v);
    cmp_a_wr_i = 1'b1; wdata_i = v; step(); cmp_a_wr_i = 1'b0;
  endtask
  task automatic wr_b(input logic [15:0] v);
    cmp_b_wr_i = 1'b1; wdata_i = v; step(); cmp_b_wr_i = 1'b0;
  endtask
  task automatic wr_top(input logic [15:0] v);
    top_wr_i = 1'b1; wdata_i = v; step(); top_wr_i = 1'b0;
  endtask
  task automatic clr_all();
    clr_ovf_i = 1'b1; clr_cmpa_i = 1'b1; clr_topreg_i = 1'b1;
    step();
    clr_ovf_i = 1'b0; clr_cmpa_i = 1'b0; clr_topreg_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "reset count", 32'(count_o), 0);
    check("R1", "reset flags", {29'd0, ovf_flag_o, cmpa_flag_o, topreg_flag_o}, 0);
    check("R10", "reset waves off", {30'd0, wave_a_o, wave_b_o}, 0);
  endtask

  task automatic t_tick_gate();
    repeat (5) step();
    check("R1", "no tick holds count", 32'(count_o), 0);
    tick_i = 1'b1;
    repeat (10) step();
    check("R1", "ten ticks", 32'(count_o), 10);
  endtask

  task automatic t_fixed_top();
    wait_count(16'h00FF); step();
    check("R2", "8-bit wrap", 32'(count_o), 0);
    check("R2", "ovf at 8-bit top", 32'(ovf_flag_o), 1);
    clr_ovf_i = 1'b1; step(); clr_ovf_i = 1'b0;
    check("R12", "ovf cleared", 32'(ovf_flag_o), 0);
    wait_count(16'h00FF);
    clr_ovf_i = 1'b1; step(); clr_ovf_i = 1'b0;
    check("R12", "set beats clear", 32'(ovf_flag_o), 1);
    top_sel_i = 3'd1;
    wait_count(16'h01FF); step();
    check("R2", "9-bit wrap", 32'(count_o), 0);
    top_sel_i = 3'd2;
    wait_count(16'h03FF); step();
    check("R2", "10-bit wrap", 32'(count_o), 0);
    top_sel_i = 3'd0;
  endtask

  task automatic t_mask();
    mode_a_i = 2'd2;
    wr_a(16'h1234);
    wait_count(16'h00FF); step();
    wait_count(16'h0034);
    check("R9", "high up to compare", 32'(wave_a_o), 1);
    step();
    check("R6", "masked compare cleared at 0x35", 32'(wave_a_o), 0);
    mode_a_i = 2'd3; #1;
    check("R10", "inverted output", 32'(wave_a_o), 1);
    mode_a_i = 2'd1; #1;
    check("R10", "mode 1 output low", 32'(wave_a_o), 0);
    mode_a_i = 2'd2;
  endtask

  task automatic t_buffer();
    wait_count(16'h0010);
    wr_a(16'h0080);
    wait_count(16'h0035);
    check("R4", "old compare still active", 32'(wave_a_o), 0);
    wait_count(16'h0000);
    wait_count(16'h0035);
    check("R4", "new compare loaded, still high", 32'(wave_a_o), 1);
    clr_cmpa_i = 1'b1; step(); clr_cmpa_i = 1'b0;
    wait_count(16'h0080);
    check("R9", "high at compare value", 32'(wave_a_o), 1);
    step();
    check("R9", "low after compare", 32'(wave_a_o), 0);
    check("R7", "cmpa flag on match", 32'(cmpa_flag_o), 1);
  endtask

  task automatic t_top_a();
    wait_count(16'h0005);
    top_sel_i = 3'd3;
    clr_all();
    wr_a(16'h0040);
    wr_b(16'h0020);
    mode_b_i = 2'd2;
    wait_count(16'h007F);
    check("R7", "flags clear before top", {30'd0, ovf_flag_o, cmpa_flag_o}, 0);
    step(); step();
    check("R2", "wrap at compare A", 32'(count_o), 0);
    check("R7", "ovf and cmpa together", {30'd0, ovf_flag_o, cmpa_flag_o}, 3);
    wait_count(16'h0020);
    check("R9", "B high at its compare", 32'(wave_b_o), 1);
    step();
    check("R9", "B low after compare", 32'(wave_b_o), 0);
    wait_count(16'h0040); step();
    check("R4", "staged A became new top", 32'(count_o), 0);
  endtask

  task automatic t_top_reg();
    wr_top(16'h0100);
    top_sel_i = 3'd4;
    clr_all();
    wait_count(16'h0010);
    wr_top(16'h0030);
    wait_count(16'h0030); step();
    check("R5", "period write applied in same period", 32'(count_o), 0);
    check("R8", "period-register flag", 32'(topreg_flag_o), 1);
    wait_count(16'h0028);
    top_wr_i = 1'b1; wdata_i = 16'h0020; clr_topreg_i = 1'b1; clr_ovf_i = 1'b1;
    step();
    top_wr_i = 1'b0; clr_topreg_i = 1'b0; clr_ovf_i = 1'b0;
    check("R3", "count continues past new low limit", 32'(count_o), 32'h29);
    wait_count(16'hFFFF);
    check("R3", "no period flags during missed run", {30'd0, ovf_flag_o, topreg_flag_o}, 0);
    step();
    check("R3", "natural wrap to zero", 32'(count_o), 0);
    check("R3", "no ovf at natural wrap", 32'(ovf_flag_o), 0);
    wait_count(16'h0020); step();
    check("R5", "new limit met after wrap", 32'(count_o), 0);
    check("R8", "period-register flag after wrap", 32'(topreg_flag_o), 1);
  endtask

  task automatic t_cmp_above_top();
    wr_a(16'h0050);
    wait_count(16'h0020); step();
    clr_cmpa_i = 1'b1; step(); clr_cmpa_i = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 70; i++) begin
        if (wave_a_o !== 1'b1) bad++;
        step();
      end
      check("R11", "low samples with compare above top", 32'(bad), 0);
    end
    check("R11", "no compare-A flag", 32'(cmpa_flag_o), 0);
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_tick_gate();
    t_fixed_top();
    t_mask();
    t_buffer();
    t_top_a();
    t_top_reg();
    t_cmp_above_top();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule